// File: doc/BRIEF.md
# Salsa20 Keystream Cipher Core

This block encrypts or decrypts a stream of 512-bit message blocks with the Salsa20 stream cipher. A start strobe captures a 256-bit shared key together with two nonce parts. The block then runs the HSalsa20 core over the key and the 128-bit first nonce part to get a 256-bit working subkey. With that subkey it runs Salsa20 in counter mode over the 64-bit second nonce part and a 64-bit block counter that starts at zero. The same iterative round engine does both jobs, one after the other.

Keystream block 0 is not used on data. Its low 256 bits come out once as a one-time key for a message authenticator placed after this block. Message block k is XORed with keystream block k+1. The XOR is its own inverse, so the same path both encrypts and decrypts. Input blocks arrive on a valid/ready stream with a per-byte keep mask and a last flag. Ciphertext comes out one cycle after each block is accepted. While one block waits at the input, the engine is already computing the next keystream block, so every slot of DOUBLE_ROUNDS+1 cycles yields one keystream block.

Top module: `salsa_stream_cipher`

## Requirements
- R1: After reset, `busy_o`, `in_ready_o`, `out_valid_o` and `otk_valid_o` are all low.
- R2: The subkey is HSalsa20 of the key and `nonce_a_i`, with no feed-forward. The input state holds the constants 0x61707865, 0x3320646e, 0x79622d32 and 0x6b206574 in words 0, 5, 10 and 15. Key words 0-3 go to state words 1-4 and key words 4-7 to state words 11-14. Nonce words 0-3 go to state words 6-9. Word i of any 32n-bit port is bits 32i+31:32i. Subkey words 0-7 are final-state words 0, 5, 10, 15, 6, 7, 8 and 9.
- R3: Keystream block n is Salsa20 (20 rounds, then the input state added word by word) over an input state laid out as in R2. The subkey takes the key positions, `nonce_b_i` words 0-1 go to state words 6-7, and counter n (low word first) goes to state words 8-9. Keystream word i is bits 32i+31:32i.
- R4: `otk_o` equals bits 255:0 of keystream block 0. `otk_valid_o` is a one-cycle pulse that rises 2*(DOUBLE_ROUNDS+1) clock edges after the edge that accepts `start_i`.
- R5: For accepted message block k (k = 0, 1, ...), `out_data_o` byte j (bits 8j+7:8j) is input byte j XOR keystream block k+1 byte j when `in_keep_i[j]` is 1, and zero otherwise.
- R6: `out_valid_o` is high for exactly the cycle after each edge with `in_valid_i && in_ready_o`. `out_last_o` is high in that cycle when that block carried `in_last_i`.
- R7: `in_ready_o` first rises 3*(DOUBLE_ROUNDS+1) edges after the start edge. When each block is accepted as soon as it is ready, `in_ready_o` comes back DOUBLE_ROUNDS edges after each acceptance, so one block is taken per slot.
- R8: Accepting a block flagged `in_last_i` drops `busy_o` at that same edge. A later start begins a fresh stream from counter 0.
- R9: `start_i` is ignored while `busy_o` is high: the running stream keeps its subkey, nonce and counter.
- R10: Feeding the ciphertext back under the same key and nonces gives the original plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a new stream when idle |
| key_i | input | 256 | Shared key, sampled at start |
| nonce_a_i | input | 128 | First nonce part, input to subkey derivation |
| nonce_b_i | input | 64 | Second nonce part, held for the whole stream |
| busy_o | output | 1 | A stream is in progress |
| otk_valid_o | output | 1 | One-cycle pulse: `otk_o` is fresh |
| otk_o | output | 256 | One-time authenticator key |
| in_valid_i | input | 1 | Input block present |
| in_ready_o | output | 1 | Keystream ready to take a block |
| in_data_i | input | 512 | Plaintext or ciphertext block |
| in_keep_i | input | 64 | Per-byte valid mask |
| in_last_i | input | 1 | Final block of the stream |
| out_valid_o | output | 1 | Output block present |
| out_data_o | output | 512 | XOR result, masked bytes zeroed |
| out_last_o | output | 1 | Output block is the final one |

## Verification
The assertions assume that `in_valid_i` is only raised together with stable data. They also assume that a block's keep mask is sampled at the same edge as the block itself, because the masked-byte property compares the output against the previous cycle's `in_keep_i`. The bench drives data, keep and last at the same falling edge as `in_valid_i` and drops valid right after the acceptance edge. It raises `start_i` only as a single-cycle pulse, and the one pulse sent during a running stream tests that start is ignored.

// File: rtl/salsa_pkg.sv
package salsa_pkg;
  typedef logic [31:0] word_t;
  typedef word_t [15:0] state_t;

  localparam word_t SIGMA0 = 32'h61707865;
  localparam word_t SIGMA1 = 32'h3320646e;
  localparam word_t SIGMA2 = 32'h79622d32;
  localparam word_t SIGMA3 = 32'h6b206574;
  localparam int BLOCK_BYTES = 64;

  function automatic word_t rotl(word_t x, int unsigned n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // one add-rotate-xor quarter round applied in place on four state words
  function automatic state_t qr_at(state_t s, int a, int b, int c, int d);
    state_t r = s;
    r[b] = r[b] ^ rotl(r[a] + r[d], 7);
    r[c] = r[c] ^ rotl(r[b] + r[a], 9);
    r[d] = r[d] ^ rotl(r[c] + r[b], 13);
    r[a] = r[a] ^ rotl(r[d] + r[c], 18);
    return r;
  endfunction

  function automatic state_t double_round(state_t s);
    state_t r = s;
    r = qr_at(r, 0, 4, 8, 12);
    r = qr_at(r, 5, 9, 13, 1);
    r = qr_at(r, 10, 14, 2, 6);
    r = qr_at(r, 15, 3, 7, 11);
    r = qr_at(r, 0, 1, 2, 3);
    r = qr_at(r, 5, 6, 7, 4);
    r = qr_at(r, 10, 11, 8, 9);
    r = qr_at(r, 15, 12, 13, 14);
    return r;
  endfunction

  // input state: constants on the diagonal, key split around a 128-bit middle
  function automatic state_t build_state(logic [255:0] k, logic [127:0] mid);
    state_t s;
    s[0]  = SIGMA0;
    s[5]  = SIGMA1;
    s[10] = SIGMA2;
    s[15] = SIGMA3;
    for (int i = 0; i < 4; i++) begin
      s[1 + i]  = k[32*i +: 32];
      s[11 + i] = k[32*(i+4) +: 32];
      s[6 + i]  = mid[32*i +: 32];
    end
    return s;
  endfunction

  function automatic state_t feed_forward(state_t fin, state_t ini);
    state_t r;
    for (int i = 0; i < 16; i++) r[i] = fin[i] + ini[i];
    return r;
  endfunction

  function automatic logic [255:0] pick_subkey(state_t s);
    return {s[9], s[8], s[7], s[6], s[15], s[10], s[5], s[0]};
  endfunction

  function automatic logic [8*BLOCK_BYTES-1:0] byte_mask(logic [BLOCK_BYTES-1:0] keep);
    logic [8*BLOCK_BYTES-1:0] m;
    for (int j = 0; j < BLOCK_BYTES; j++) m[8*j +: 8] = {8{keep[j]}};
    return m;
  endfunction
endpackage

// File: rtl/salsa_round_core.sv
module salsa_round_core
  import salsa_pkg::*;
#(
  parameter int DOUBLE_ROUNDS = 10,
  parameter int DR_PER_CYCLE  = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  state_t init_i,
  output logic   done_o,
  output state_t final_o,
  output state_t init_o
);
  localparam int STEPS = DOUBLE_ROUNDS / DR_PER_CYCLE;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [CNT_W-1:0] left_q;
  state_t st_q, base_q;
  state_t chain [DR_PER_CYCLE+1];

  assign chain[0] = st_q;
  generate
    for (genvar g = 0; g < DR_PER_CYCLE; g++) begin : g_unroll
      assign chain[g+1] = double_round(chain[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      done_o <= 1'b0;
      st_q   <= '0;
      base_q <= '0;
    end else if (load_i) begin
      st_q   <= init_i;
      base_q <= init_i;
      left_q <= CNT_W'(STEPS);
      done_o <= 1'b0;
    end else begin
      done_o <= (left_q == CNT_W'(1));
      if (left_q != '0) begin
        st_q   <= chain[DR_PER_CYCLE];
        left_q <= left_q - CNT_W'(1);
      end
    end
  end

  assign final_o = st_q;
  assign init_o  = base_q;

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_result_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> $stable(st_q));
endmodule

// File: rtl/salsa_xor_mask.sv
module salsa_xor_mask
  import salsa_pkg::*;
#(
  parameter int NBYTES = BLOCK_BYTES
) (
  input  logic [8*NBYTES-1:0] data_i,
  input  logic [8*NBYTES-1:0] ks_i,
  input  logic [NBYTES-1:0]   keep_i,
  output logic [8*NBYTES-1:0] data_o
);
  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign data_o[8*b +: 8] = keep_i[b] ? (data_i[8*b +: 8] ^ ks_i[8*b +: 8]) : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/salsa_stream_cipher.sv
module salsa_stream_cipher
  import salsa_pkg::*;
#(
  parameter int DOUBLE_ROUNDS = 10,
  parameter int DR_PER_CYCLE  = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [255:0] key_i,
  input  logic [127:0] nonce_a_i,
  input  logic [63:0]  nonce_b_i,
  output logic         busy_o,
  output logic         otk_valid_o,
  output logic [255:0] otk_o,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [511:0] in_data_i,
  input  logic [63:0]  in_keep_i,
  input  logic         in_last_i,
  output logic         out_valid_o,
  output logic [511:0] out_data_o,
  output logic         out_last_o
);
  localparam int BLK_W = 8 * BLOCK_BYTES;

  typedef enum logic [1:0] {S_IDLE, S_DERIVE, S_OTK, S_STREAM} phase_t;

  phase_t             phase_q;
  logic [255:0]       subkey_q;
  logic [63:0]        nonce_b_q;
  logic [63:0]        ctr_q;
  logic [BLK_W-1:0]   buf_q;
  logic               buf_full_q, pend_q;

  logic   core_load, core_done;
  state_t core_init, core_final, core_base, ks_now;
  logic [255:0] subkey_new;
  logic [BLK_W-1:0] xor_out;
  logic   accept, core_has, take_core, last_accept;

  salsa_round_core #(.DOUBLE_ROUNDS(DOUBLE_ROUNDS), .DR_PER_CYCLE(DR_PER_CYCLE)) u_core (
    .clk(clk), .rst_n(rst_n), .load_i(core_load), .init_i(core_init),
    .done_o(core_done), .final_o(core_final), .init_o(core_base));

  salsa_xor_mask #(.NBYTES(BLOCK_BYTES)) u_xor (
    .data_i(in_data_i), .ks_i(buf_q), .keep_i(in_keep_i), .data_o(xor_out));

  assign subkey_new  = pick_subkey(core_final);
  assign ks_now      = feed_forward(core_final, core_base);
  assign in_ready_o  = (phase_q == S_STREAM) && buf_full_q;
  assign accept      = in_valid_i && in_ready_o;
  assign last_accept = accept && in_last_i;
  assign core_has    = core_done || pend_q;
  assign take_core   = (phase_q == S_STREAM) && core_has && (!buf_full_q || accept) && !last_accept;
  assign busy_o      = (phase_q != S_IDLE);

  always_comb begin
    core_load = 1'b0;
    core_init = '0;
    unique case (phase_q)
      S_IDLE: if (start_i) begin
        core_load = 1'b1;
        core_init = build_state(key_i, nonce_a_i);
      end
      S_DERIVE: if (core_done) begin
        core_load = 1'b1;
        core_init = build_state(subkey_new, {ctr_q, nonce_b_q});
      end
      S_OTK: if (core_done) begin
        core_load = 1'b1;
        core_init = build_state(subkey_q, {ctr_q, nonce_b_q});
      end
      S_STREAM: if (take_core) begin
        core_load = 1'b1;
        core_init = build_state(subkey_q, {ctr_q, nonce_b_q});
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= S_IDLE;
      subkey_q    <= '0;
      nonce_b_q   <= '0;
      ctr_q       <= '0;
      buf_q       <= '0;
      buf_full_q  <= 1'b0;
      pend_q      <= 1'b0;
      otk_valid_o <= 1'b0;
      otk_o       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else begin
      otk_valid_o <= 1'b0;
      out_valid_o <= accept;
      out_last_o  <= last_accept;
      if (accept) out_data_o <= xor_out;
      if (core_load && phase_q != S_IDLE) ctr_q <= ctr_q + 64'd1;
      unique case (phase_q)
        S_IDLE: if (start_i) begin
          phase_q   <= S_DERIVE;
          nonce_b_q <= nonce_b_i;
          ctr_q     <= '0;
        end
        S_DERIVE: if (core_done) begin
          subkey_q <= subkey_new;
          phase_q  <= S_OTK;
        end
        S_OTK: if (core_done) begin
          otk_o       <= ks_now[255:0];
          otk_valid_o <= 1'b1;
          phase_q     <= S_STREAM;
          buf_full_q  <= 1'b0;
          pend_q      <= 1'b0;
        end
        S_STREAM: begin
          if (last_accept) begin
            phase_q    <= S_IDLE;
            buf_full_q <= 1'b0;
            pend_q     <= 1'b0;
          end else begin
            if (take_core) begin
              buf_q      <= ks_now;
              buf_full_q <= 1'b1;
            end else if (accept) begin
              buf_full_q <= 1'b0;
            end
            pend_q <= core_has && !take_core;
          end
        end
        default: phase_q <= S_IDLE;
      endcase
    end
  end

  assert_ready_in_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> busy_o);
  assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready_o && !in_valid_i) |=> in_ready_o);
  assert_out_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(in_valid_i && in_ready_o));
  assert_otk_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    otk_valid_o |=> !otk_valid_o);
  assert_masked_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((out_data_o & ~byte_mask($past(in_keep_i))) == '0));
  assert_last_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |-> !busy_o);
endmodule

// File: tb/salsa_stream_cipher_bench.sv
module salsa_stream_cipher_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [255:0] key_i = '0;
  logic [127:0] nonce_a_i = '0;
  logic [63:0] nonce_b_i = '0;
  logic busy_o, otk_valid_o, in_ready_o, out_valid_o, out_last_o;
  logic [255:0] otk_o;
  logic in_valid_i = 1'b0;
  logic [511:0] in_data_i = '0;
  logic [63:0] in_keep_i = '0;
  logic in_last_i = 1'b0;
  logic [511:0] out_data_o;

  int checks = 0;
  int errors = 0;
  logic [511:0] ct_store [4];

  localparam int DR = 10;
  localparam int NV = 3;
  localparam logic [255:0] T_KEY [NV] = '{
    256'h0f0e0d0c0b0a09080706050403020100_1f1e1d1c1b1a19181716151413121110,
    256'h80000000000000000000000000000000_00000000000000000000000000000001,
    256'hdeadbeef01234567cafef00d89abcdef_5555aaaa3333cccc0f0ff0f012345678};
  localparam logic [127:0] T_NA [NV] = '{
    128'h00000000000000000000000000000000,
    128'h69696ee955b62b73cd62bda875fc73d6,
    128'hffffffffffffffff0000000000000001};
  localparam logic [63:0] T_NB [NV] = '{
    64'h0000000000000000, 64'h8219e0036b7a0b37, 64'h0123456789abcdef};
  localparam int T_NBLK [NV] = '{1, 3, 2};
  localparam logic [63:0] T_LKEEP [NV] = '{
    64'hffffffffffffffff, 64'h00000000000000ff, 64'hf0f0f0f0f0f0f0f0};

  salsa_stream_cipher u_salsa_stream_cipher (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
    .nonce_a_i(nonce_a_i), .nonce_b_i(nonce_b_i), .busy_o(busy_o),
    .otk_valid_o(otk_valid_o), .otk_o(otk_o), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .in_data_i(in_data_i), .in_keep_i(in_keep_i),
    .in_last_i(in_last_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_last_o(out_last_o));

  always #10 clk = ~clk;

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // reference: array form, quads walked from an index table
  function automatic logic [511:0] ref_block(logic [255:0] k, logic [127:0] mid, bit ff);
    int quad [8][4] = '{'{0,4,8,12}, '{5,9,13,1}, '{10,14,2,6}, '{15,3,7,11},
                        '{0,1,2,3}, '{5,6,7,4}, '{10,11,8,9}, '{15,12,13,14}};
    int hpick [8] = '{0,5,10,15,6,7,8,9};
    logic [31:0] x [16];
    logic [31:0] y [16];
    logic [511:0] r = '0;
    x[0] = 32'h61707865; x[5] = 32'h3320646e; x[10] = 32'h79622d32; x[15] = 32'h6b206574;
    for (int i = 0; i < 4; i++) begin
      x[1+i] = k[32*i +: 32]; x[11+i] = k[128+32*i +: 32]; x[6+i] = mid[32*i +: 32];
    end
    y = x;
    for (int rd = 0; rd < DR; rd++)
      for (int q = 0; q < 8; q++) begin
        int a = quad[q][0]; int b = quad[q][1]; int c = quad[q][2]; int d = quad[q][3];
        y[b] ^= rl(y[a] + y[d], 7);
        y[c] ^= rl(y[b] + y[a], 9);
        y[d] ^= rl(y[c] + y[b], 13);
        y[a] ^= rl(y[d] + y[c], 18);
      end
    if (ff) for (int i = 0; i < 16; i++) r[32*i +: 32] = y[i] + x[i];
    else    for (int i = 0; i < 8; i++)  r[32*i +: 32] = y[hpick[i]];
    return r;
  endfunction

  function automatic logic [511:0] msg(int v, int b);
    logic [511:0] m;
    for (int i = 0; i < 16; i++) m[32*i +: 32] = 32'(v*131 + b*17 + i + 1) * 32'h9e3779b9;
    return m;
  endfunction

  function automatic logic [511:0] kmask(logic [63:0] keep);
    logic [511:0] m;
    for (int j = 0; j < 64; j++) m[8*j +: 8] = keep[j] ? 8'hff : 8'h00;
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [255:0] k, input logic [127:0] na, input logic [63:0] nb,
                         input int nblk, input logic [63:0] lk, input int v,
                         input bit use_ct, input bit poke);
    logic [255:0] sub;
    logic [511:0] ks0, ks, dat, exp;
    logic [63:0] keep;
    int n;
    sub = ref_block(k, na, 1'b0)[255:0];
    ks0 = ref_block(sub, {64'd0, nb}, 1'b1);
    @(negedge clk);
    key_i = k; nonce_a_i = na; nonce_b_i = nb; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!otk_valid_o) begin @(negedge clk); n++; end
    chk(n == 2*(DR+1), "R4 otk latency", 512'(n), 512'(2*(DR+1)));
    chk(otk_o == ks0[255:0], "R2 R3 R4 otk value", 512'(otk_o), 512'(ks0[255:0]));
    while (!in_ready_o) begin @(negedge clk); n++; end
    chk(n == 3*(DR+1), "R7 first ready", 512'(n), 512'(3*(DR+1)));
    for (int b = 0; b < nblk; b++) begin
      if (b > 0) begin
        n = 0;
        if (poke && b == 1) begin
          start_i = 1'b1; key_i = ~k; nonce_b_i = ~nb;
          @(negedge clk); n++;
          start_i = 1'b0;
        end
        while (!in_ready_o) begin @(negedge clk); n++; end
        chk(n == DR, "R7 slot gap", 512'(n), 512'(DR));
      end
      ks = ref_block(sub, {64'(b + 1), nb}, 1'b1);
      keep = (b == nblk - 1) ? lk : '1;
      dat = use_ct ? ct_store[b] : msg(v, b);
      exp = use_ct ? (msg(v, b) & kmask(keep)) : ((dat ^ ks) & kmask(keep));
      in_valid_i = 1'b1; in_data_i = dat; in_keep_i = keep; in_last_i = (b == nblk - 1);
      @(negedge clk);
      in_valid_i = 1'b0; in_last_i = 1'b0;
      chk(out_valid_o == 1'b1, "R6 out_valid after accept", 512'(out_valid_o), 512'(1));
      if (use_ct) chk(out_data_o == exp, "R10 decrypt round trip", out_data_o, exp);
      else if (poke) chk(out_data_o == exp, "R9 start ignored while busy", out_data_o, exp);
      else chk(out_data_o == exp, "R3 R5 ciphertext", out_data_o, exp);
      chk(out_last_o == (b == nblk - 1), "R6 out_last", 512'(out_last_o), 512'(b == nblk - 1));
      ct_store[b] = out_data_o;
      if (b == nblk - 1) chk(busy_o == 1'b0, "R8 idle after last", 512'(busy_o), 512'(0));
    end
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R6 out_valid single cycle", 512'(out_valid_o), 512'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !in_ready_o && !out_valid_o && !otk_valid_o, "R1 reset state",
        512'({busy_o, in_ready_o, out_valid_o, otk_valid_o}), 512'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !in_ready_o, "R1 idle after reset", 512'({busy_o, in_ready_o}), 512'(0));
    // table walk: back-to-back streams also show R8 restart from counter 0
    for (int v = 0; v < NV; v++)
      run_vec(T_KEY[v], T_NA[v], T_NB[v], T_NBLK[v], T_LKEEP[v], v, 1'b0, 1'b0);
    // R10: encrypt a full two-block stream, then decrypt it
    run_vec(T_KEY[2], T_NA[1], T_NB[0], 2, '1, 7, 1'b0, 1'b0);
    run_vec(T_KEY[2], T_NA[1], T_NB[0], 2, '1, 7, 1'b1, 1'b0);
    // R9: start pulse with other key mid-stream is ignored
    run_vec(T_KEY[1], T_NA[2], T_NB[2], 3, 64'h8000000000000001, 4, 1'b0, 1'b1);
    // R8: same vector again after the poke gives the same first block
    run_vec(T_KEY[0], T_NA[0], T_NB[0], 1, '1, 0, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule